// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block sequences the external memory bus of a small 8-bit microcontroller core. Each machine cycle lasts twelve oscillator clocks, made of six states of two phases each. At the end of every machine cycle the controller takes one request from the core, or none. A request is a program fetch, a code-table read, an external data read or an external data write. The controller then runs one bus cycle. The low address byte goes out on a multiplexed address/data port and is latched externally by the address latch enable (ALE) pulse. The data byte then uses the same port. The high port carries either the upper address byte or the core's port 2 register value.

With no bus traffic, ALE runs free at two pulses per machine cycle. An external data access drops one of those pulses. A control input can silence the free-running pulses so that ALE appears only around bus accesses. A second input, which indicates execution from external program memory, overrides that control input.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: A machine cycle is 12 clocks, numbered 0 to 11, and `cyc_end` is high in slot 11 only. In an idle cycle with free-running ALE, `ale` is high for exactly one clock in slot 1 and one clock in slot 7.
- R2: A data read (`req_kind`=2) or data write (`req_kind`=3) cycle keeps the slot 1 ALE pulse and omits the slot 7 pulse, so it has exactly one pulse.
- R3: With `ale_off`=1 and `ext_exec`=0, an idle cycle has no ALE pulse. A data cycle still has one pulse (slot 1). A fetch (`req_kind`=0) or code-table read (`req_kind`=1) cycle still has two pulses (slots 1 and 7).
- R4: With `ext_exec`=1, `ale_off` has no effect, and an idle cycle has two ALE pulses.
- R5: In any bus cycle, `p0_oe` is 1 and `p0_out` equals the low address byte in slots 0 to 2.
- R6: In a data write, `wr_n` is low in slots 4 to 9 only, and `p0_out` carries the write byte with `p0_oe`=1 in slots 3 to 11.
- R7: In a data read, `rd_n` is low in slots 4 to 9 only and `p0_oe` is 0 in slots 3 to 11. The value of `p0_in` in slot 9 appears on `rdata`, with `rdata_vld` high in slot 10 only.
- R8: In a fetch or code-table read, `psen_n` is low in slots 3 to 5 only. The value of `p0_in` in slot 5 appears on `rdata`, with `rdata_vld` high in slot 6 only.
- R9: For a fetch, a code-table read, or a data access with `req_short`=0, `p2_out` equals the upper address byte for the whole cycle.
- R10: For a data access with `req_short`=1, and for an idle cycle, `p2_out` equals the `p2_reg` value sampled with the request.
- R11: While `rst` is high (held 24 clocks or more), `ale` is 0, all strobes are high, `p0_oe` is 0 and `p2_out` is FFH. `p2_out` stays FFH through the first machine cycle after release.
- R12: Requests are sampled only in the clock where `cyc_end` is high. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present for the next machine cycle |
| req_kind | input | 2 | 0 fetch, 1 code-table read, 2 data read, 3 data write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_short | input | 1 | Data access uses an 8-bit register-indirect address |
| p2_reg | input | 8 | Port 2 register value from the core |
| ale_off | input | 1 | Suppress free-running ALE pulses |
| ext_exec | input | 1 | Core executes from external program memory |
| p0_in | input | 8 | Low port pin values |
| p0_out | output | 8 | Low port drive value |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | High port value |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rdata | output | 8 | Last byte read from the bus |
| rdata_vld | output | 1 | One-clock pulse when rdata is new |
| cyc_end | output | 1 | Last clock of the machine cycle |

## Verification
The bench runs idle, fetch, code-table, data-read and data-write cycles. It records every output in each of the twelve slots and counts the ALE pulses per cycle. The idle and data cycles are then repeated with the suppress input set, both with and without external execution. Comparing these runs tells a pulse that is dropped only by a data access apart from one that the suppress input silences, and shows that external execution overrides the suppression. Data reads are run once with a short and once with a long pointer, each with a port 2 register value that differs from the upper address byte, so the two possible sources of `p2_out` cannot be confused. A reset in the middle of a cycle checks the return to the idle levels.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      CK_IDLE  = 3'd0,
      CK_FETCH = 3'd1,
      CK_CODE  = 3'd2,
      CK_DRD   = 3'd3,
      CK_DWR   = 3'd4
   } cyc_kind_e;

   function automatic logic kind_is_data(cyc_kind_e k);
      return (k == CK_DRD) || (k == CK_DWR);
   endfunction

   function automatic logic kind_is_prog(cyc_kind_e k);
      return (k == CK_FETCH) || (k == CK_CODE);
   endfunction

   function automatic cyc_kind_e kind_from_req(logic [1:0] code);
      case (code)
         2'd0:    return CK_FETCH;
         2'd1:    return CK_CODE;
         2'd2:    return CK_DRD;
         default: return CK_DWR;
      endcase
   endfunction
endpackage

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
   parameter int MC_LEN = 12,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] slot,
   output logic             last
);
   localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(MC_LEN - 1);

   assign last = (slot == LAST_SLOT);

   generate
      if ((1 << CNT_W) == MC_LEN) begin : g_wrap_free
         always_ff @(posedge clk) begin
            if (rst) slot <= '0;
            else     slot <= slot + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk) begin
            if (rst)       slot <= '0;
            else if (last) slot <= '0;
            else           slot <= slot + 1'b1;
         end
      end
   endgenerate

   AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      slot <= LAST_SLOT);                                    // R1
   AST_SLOT_WRAPS: assert property (@(posedge clk) disable iff (rst)
      last |=> (slot == '0));                                // R1
endmodule

// File: rtl/xbus_ale_gen.sv
module xbus_ale_gen
   import xbus_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int SLOT_A = 1,
   parameter int SLOT_B = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] slot,
   input  cyc_kind_e        kind,
   input  logic             ale_off,
   input  logic             ext_exec,
   output logic             ale
);
   localparam logic [CNT_W-1:0] SA = CNT_W'(SLOT_A);
   localparam logic [CNT_W-1:0] SB = CNT_W'(SLOT_B);

   logic free_run;
   assign free_run = !ale_off || ext_exec;

   always_comb begin
      ale = 1'b0;
      if (slot == SA) begin
         ale = (kind != CK_IDLE) || free_run;
      end else if (slot == SB) begin
         case (kind)
            CK_FETCH, CK_CODE: ale = 1'b1;
            CK_IDLE:           ale = free_run;
            default:           ale = 1'b0;
         endcase
      end
   end

   AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      ale |=> !ale);                                         // R1
   AST_ALE_BUS_PULSE: assert property (@(posedge clk) disable iff (rst)
      (slot == SA && kind != CK_IDLE) |-> ale);              // R3
endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux
   import xbus_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 4,
   parameter int ADDR_LAST  = 2,
   parameter int PSEN_FIRST = 3,
   parameter int PSEN_LAST  = 5,
   parameter int STB_FIRST  = 4,
   parameter int STB_LAST   = 9
) (
   input  logic [CNT_W-1:0]  slot,
   input  cyc_kind_e         kind,
   input  logic [DATA_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] p2_val,
   output logic [DATA_W-1:0] p0_out,
   output logic              p0_oe,
   output logic [DATA_W-1:0] p2_out,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n
);
   logic in_addr, in_psen, in_stb;

   assign in_addr = (slot <= CNT_W'(ADDR_LAST));
   assign in_psen = (slot >= CNT_W'(PSEN_FIRST)) && (slot <= CNT_W'(PSEN_LAST));
   assign in_stb  = (slot >= CNT_W'(STB_FIRST))  && (slot <= CNT_W'(STB_LAST));

   always_comb begin
      p0_out = '1;
      p0_oe  = 1'b0;
      if (kind != CK_IDLE && in_addr) begin
         p0_out = addr_lo;
         p0_oe  = 1'b1;
      end else if (kind == CK_DWR) begin
         p0_out = wdata;
         p0_oe  = 1'b1;
      end
   end

   assign psen_n = !(kind_is_prog(kind) && in_psen);
   assign rd_n   = !((kind == CK_DRD) && in_stb);
   assign wr_n   = !((kind == CK_DWR) && in_stb);
   assign p2_out = p2_val;
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
   import xbus_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 16,
   parameter int N_STATES = 6,
   parameter int N_PHASES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_short,
   input  logic [DATA_W-1:0] p2_reg,
   input  logic              ale_off,
   input  logic              ext_exec,
   input  logic [DATA_W-1:0] p0_in,
   output logic [DATA_W-1:0] p0_out,
   output logic              p0_oe,
   output logic [DATA_W-1:0] p2_out,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld,
   output logic              cyc_end
);
   localparam int MC_LEN = N_STATES * N_PHASES;
   localparam int CNT_W  = $clog2(MC_LEN);
   // slot index of state s (1-based), phase p (1-based)
   localparam int ALE_A      = 0 * N_PHASES + (N_PHASES - 1);
   localparam int ALE_B      = 3 * N_PHASES + (N_PHASES - 1);
   localparam int ADDR_LAST  = 1 * N_PHASES;
   localparam int PSEN_FIRST = 1 * N_PHASES + (N_PHASES - 1);
   localparam int PSEN_LAST  = 2 * N_PHASES + (N_PHASES - 1);
   localparam int STB_FIRST  = 2 * N_PHASES;
   localparam int STB_LAST   = 4 * N_PHASES + (N_PHASES - 1);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("ADDR_W must be twice DATA_W");
      end
      if (N_STATES < 6 || N_PHASES < 2) begin : g_bad_cycle
         $error("machine cycle needs at least six states of two phases");
      end
   endgenerate

   logic [CNT_W-1:0]  slot;
   logic              last;
   cyc_kind_e         kind_q, kind_d;
   logic [DATA_W-1:0] addr_lo_q, wdata_q, p2_q, p2_d, rdata_q;
   logic              vld_q, capture;

   xbus_timebase #(.MC_LEN(MC_LEN), .CNT_W(CNT_W)) tb_i (
      .clk(clk), .rst(rst), .slot(slot), .last(last)
   );

   xbus_ale_gen #(.CNT_W(CNT_W), .SLOT_A(ALE_A), .SLOT_B(ALE_B)) ale_i (
      .clk(clk), .rst(rst), .slot(slot), .kind(kind_q),
      .ale_off(ale_off), .ext_exec(ext_exec), .ale(ale)
   );

   xbus_port_mux #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_LAST(ADDR_LAST),
      .PSEN_FIRST(PSEN_FIRST), .PSEN_LAST(PSEN_LAST),
      .STB_FIRST(STB_FIRST), .STB_LAST(STB_LAST)
   ) mux_i (
      .slot(slot), .kind(kind_q), .addr_lo(addr_lo_q), .wdata(wdata_q),
      .p2_val(p2_q), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
   );

   always_comb begin
      kind_d = req_valid ? kind_from_req(req_kind) : CK_IDLE;
      if (req_valid && (kind_is_prog(kind_d) || !req_short))
         p2_d = req_addr[ADDR_W-1 -: DATA_W];
      else
         p2_d = p2_reg;
   end

   assign capture = (kind_is_prog(kind_q) && slot == CNT_W'(PSEN_LAST)) ||
                    (kind_q == CK_DRD && slot == CNT_W'(STB_LAST));

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q    <= CK_IDLE;
         addr_lo_q <= '0;
         wdata_q   <= '0;
         p2_q      <= '1;
         rdata_q   <= '0;
         vld_q     <= 1'b0;
      end else begin
         vld_q <= capture;
         if (capture) rdata_q <= p0_in;
         if (last) begin
            kind_q    <= kind_d;
            addr_lo_q <= req_addr[DATA_W-1:0];
            wdata_q   <= req_wdata;
            p2_q      <= p2_d;
         end
      end
   end

   assign rdata     = rdata_q;
   assign rdata_vld = vld_q;
   assign cyc_end   = last;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
      $countones({!psen_n, !rd_n, !wr_n}) <= 1);             // R12
   AST_RD_FLOATS_P0: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> !p0_oe);                                     // R7
   AST_WR_DRIVES_P0: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> p0_oe);                                      // R6
   AST_PSEN_HELD: assert property (@(posedge clk) disable iff (rst)
      $fell(psen_n) |=> !psen_n);                            // R8
   AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
      rdata_vld |-> $rose(rd_n) || $rose(psen_n));           // R7
   AST_STROBE_NOT_AT_ALE: assert property (@(posedge clk) disable iff (rst)
      ale |-> (psen_n && rd_n && wr_n));                     // R12
endmodule

// File: tb/xbus_cycle_ctrl_tb.sv
module xbus_cycle_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0] req_wdata = 8'h0;
   logic       req_short = 1'b0;
   logic [7:0] p2_reg = 8'h00;
   logic       ale_off = 1'b0;
   logic       ext_exec = 1'b0;
   logic [7:0] p0_in = 8'h00;
   logic [7:0] p0_out, p2_out, rdata;
   logic       p0_oe, ale, psen_n, rd_n, wr_n, rdata_vld, cyc_end;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [11:0] s_ale, s_psen, s_rd, s_wr, s_oe, s_vld;
   logic [7:0]  s_p0 [12];
   logic [7:0]  s_p2 [12];
   logic [7:0]  s_rdata [12];

   always #10 clk = ~clk;

   xbus_cycle_ctrl dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_short(req_short),
      .p2_reg(p2_reg), .ale_off(ale_off), .ext_exec(ext_exec), .p0_in(p0_in),
      .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .ale(ale),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata),
      .rdata_vld(rdata_vld), .cyc_end(cyc_end)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one machine cycle, request placed where cyc_end is high
   task automatic run_cycle(input bit v, input logic [1:0] k, input logic [15:0] a,
                            input logic [7:0] wd, input bit sh);
      while (!cyc_end) @(negedge clk);
      req_valid = v; req_kind = k; req_addr = a; req_wdata = wd; req_short = sh;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (i == 0) req_valid = 1'b0;
         s_ale[i] = ale; s_psen[i] = psen_n; s_rd[i] = rd_n; s_wr[i] = wr_n;
         s_oe[i] = p0_oe; s_vld[i] = rdata_vld;
         s_p0[i] = p0_out; s_p2[i] = p2_out; s_rdata[i] = rdata;
         if (i == 11) chk(cyc_end == 1'b1, "R1 cyc_end in slot 11", cyc_end, 1);
      end
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (26) @(negedge clk);
      chk(ale == 0 && psen_n && rd_n && wr_n && !p0_oe, "R11 reset idle levels",
          {ale, psen_n, rd_n, wr_n, p0_oe}, 5'b01110);
      chk(p2_out == 8'hFF, "R11 reset p2", p2_out, 8'hFF);
      p2_reg = 8'h5A;
      rst = 1'b0;
      @(negedge clk);
      chk(p2_out == 8'hFF, "R11 p2 first cycle", p2_out, 8'hFF);
   endtask

   task automatic t_idle;
      ale_off = 0; ext_exec = 0; p2_reg = 8'h5A;
      run_cycle(0, 0, 0, 0, 0);
      chk(s_ale == 12'h082, "R1 idle ALE slots", s_ale, 12'h082);
      chk(s_p2[4] == 8'h5A, "R10 idle p2 from register", s_p2[4], 8'h5A);
      chk(s_psen == 12'hFFF && s_rd == 12'hFFF && s_wr == 12'hFFF,
          "R12 idle no strobe", {s_psen[0], s_rd[0], s_wr[0]}, 3'b111);
   endtask

   task automatic t_fetch(input logic [1:0] k, input string tag);
      p0_in = 8'hA5; p2_reg = 8'h11;
      run_cycle(1, k, 16'hC37E, 0, 0);
      chk(s_ale == 12'h082, {tag, " two ALE pulses"}, s_ale, 12'h082);
      chk(s_psen == ~12'h038, "R8 PSEN slots 3..5", s_psen, ~12'h038);
      chk(s_oe == 12'h007 && s_p0[1] == 8'h7E, "R5 low address on p0",
          {s_oe, s_p0[1]}, {12'h007, 8'h7E});
      chk(s_p2[0] == 8'hC3 && s_p2[11] == 8'hC3, "R9 p2 high address fetch",
          s_p2[6], 8'hC3);
      chk(s_vld == 12'h040 && s_rdata[6] == 8'hA5, "R8 fetch capture",
          {s_vld, s_rdata[6]}, {12'h040, 8'hA5});
   endtask

   task automatic t_read(input bit sh);
      p0_in = 8'h3C; p2_reg = 8'h9D;
      run_cycle(1, 2'd2, 16'h4812, 0, sh);
      chk(s_ale == 12'h002, "R2 data read one ALE", s_ale, 12'h002);
      chk(s_rd == ~12'h3F0, "R7 RD slots 4..9", s_rd, ~12'h3F0);
      chk(s_oe == 12'h007, "R7 p0 released", s_oe, 12'h007);
      chk(s_vld == 12'h400 && s_rdata[10] == 8'h3C, "R7 read capture",
          {s_vld, s_rdata[10]}, {12'h400, 8'h3C});
      if (sh) chk(s_p2[5] == 8'h9D, "R10 short pointer p2", s_p2[5], 8'h9D);
      else    chk(s_p2[5] == 8'h48, "R9 long pointer p2", s_p2[5], 8'h48);
      chk(s_psen == 12'hFFF && s_wr == 12'hFFF, "R12 only RD", s_psen, 12'hFFF);
   endtask

   task automatic t_write;
      p2_reg = 8'h22;
      run_cycle(1, 2'd3, 16'h0155, 8'hE7, 1);
      chk(s_ale == 12'h002, "R2 data write one ALE", s_ale, 12'h002);
      chk(s_wr == ~12'h3F0, "R6 WR slots 4..9", s_wr, ~12'h3F0);
      chk(s_oe == 12'hFFF && s_p0[3] == 8'hE7 && s_p0[11] == 8'hE7,
          "R6 write byte driven", s_p0[3], 8'hE7);
      chk(s_p0[0] == 8'h55, "R5 write address low", s_p0[0], 8'h55);
      chk(s_p2[2] == 8'h22, "R10 short write p2", s_p2[2], 8'h22);
   endtask

   task automatic t_ale_off;
      ale_off = 1; ext_exec = 0;
      run_cycle(0, 0, 0, 0, 0);
      chk(s_ale == 12'h000, "R3 idle suppressed", s_ale, 12'h000);
      run_cycle(1, 2'd2, 16'h1234, 0, 0);
      chk(s_ale == 12'h002, "R3 data keeps one pulse", s_ale, 12'h002);
      run_cycle(1, 2'd1, 16'h2345, 0, 0);
      chk(s_ale == 12'h082, "R3 code read two pulses", s_ale, 12'h082);
      ext_exec = 1;
      run_cycle(0, 0, 0, 0, 0);
      chk(s_ale == 12'h082, "R4 external exec overrides", s_ale, 12'h082);
      run_cycle(1, 2'd3, 16'h3456, 8'h01, 0);
      chk(s_ale == 12'h002, "R4 data still drops one", s_ale, 12'h002);
      ale_off = 0; ext_exec = 0;
   endtask

   task automatic t_req_timing;
      // request held away from cyc_end must not start a cycle
      while (!cyc_end) @(negedge clk);
      @(negedge clk);
      req_valid = 1; req_kind = 2'd3; req_addr = 16'h00AA;
      repeat (10) @(negedge clk);
      chk(wr_n == 1'b1 && p0_oe == 1'b0, "R12 no mid-cycle start",
          {wr_n, p0_oe}, 2'b10);
      req_valid = 0;
   endtask

   task automatic t_mid_reset;
      p2_reg = 8'h77;
      while (!cyc_end) @(negedge clk);
      req_valid = 1; req_kind = 2'd2; req_addr = 16'hABCD; req_short = 0;
      repeat (6) @(negedge clk);
      req_valid = 0;
      rst = 1;
      repeat (24) @(negedge clk);
      chk(rd_n && psen_n && wr_n && !ale && !p0_oe && p2_out == 8'hFF,
          "R11 mid-cycle reset", p2_out, 8'hFF);
      rst = 0;
      run_cycle(0, 0, 0, 0, 0);
      chk(s_ale == 12'h082, "R1 idle after reset", s_ale, 12'h082);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_fetch(2'd0, "R3 fetch");
      t_fetch(2'd1, "R3 code");
      t_read(1'b0);
      t_read(1'b1);
      t_write();
      t_ale_off();
      t_req_timing();
      t_mid_reset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule